// File: doc/BRIEF.md
# Modem Status Change Monitor

This block watches the three active-low modem control inputs of a serial port: carrier detect, data set ready and ring indicator. It brings each one into the core clock domain through a short chain of flops. It reports the carrier and data-set-ready levels as active-high status bits. It also keeps a sticky "line changed" bit, which the host clears by reading the status register.

Whether an input edge counts depends on the terminal-ready (DTR) state that the port is driving. With DTR on, both edges of carrier detect and data set ready set the change bit. With DTR off, only a falling edge of ring indicator sets it, and only when the port is not in its internal loop mode.

The interrupt output is registered. It is the OR of the change bit and an interrupt request from the port's other status sources. It is released when the status register is read or when master reset is applied.

Top module: `mdm_status_irq`

## Requirements
- R1: With `dtr_on` high, a falling edge and a rising edge of `cd_n` each set `chg_stat`.
- R2: With `dtr_on` high, a falling edge and a rising edge of `dsr_n` each set `chg_stat`.
- R3: With `dtr_on` low and `loop_mode` low, a falling edge of `ri_n` sets `chg_stat`, and a rising edge of `ri_n` does not.
- R4: Carrier and data-set-ready edges have no effect while `dtr_on` is low. Ring edges have no effect while `dtr_on` is high. A change of `dtr_on` alone never sets `chg_stat`.
- R5: While `loop_mode` is high, a falling edge of `ri_n` does not set `chg_stat`.
- R6: Once set, `chg_stat` stays at 1 until a cycle with `status_rd` high, and it reads 0 on the cycle after that read.
- R7: If a qualified edge is detected in the same cycle as `status_rd`, `chg_stat` stays at 1.
- R8: `cd_stat` is the complement of `cd_n`, and `dsr_stat` is the complement of `dsr_n`. Each is 1 while its pin is low.
- R9: `irq` is 1 whenever `chg_stat` is 1 or `other_irq` was high on the previous cycle. It falls together with `chg_stat` after a status read.
- R10: While `rst` is high, `chg_stat`, `irq`, `cd_stat` and `dsr_stat` are all 0 from the next clock edge. The synchroniser flops take the idle (high) pin level.
- R11: A pin change shows up on `chg_stat`, `irq` and the level bits on the SYNC_STAGES+1-th rising edge after it is applied, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Master reset, synchronous, active high |
| cd_n | input | 1 | Carrier detect pin, active low, asynchronous |
| dsr_n | input | 1 | Data set ready pin, active low, asynchronous |
| ri_n | input | 1 | Ring indicator pin, active low, asynchronous |
| dtr_on | input | 1 | Terminal-ready output state of the port, 1 = on |
| loop_mode | input | 1 | Internal loop configuration, 1 = loop |
| status_rd | input | 1 | One-cycle strobe for a status register read |
| other_irq | input | 1 | Interrupt request from the other status sources |
| cd_stat | output | 1 | Carrier present status bit |
| dsr_stat | output | 1 | Data set ready status bit |
| chg_stat | output | 1 | Sticky data set change status bit |
| irq | output | 1 | Interrupt request output |

## Verification
A pin change passes through two synchroniser flops and one result register. `chg_stat`, `irq` and the level bits are therefore due on the third rising edge after the change. The bench samples them on the falling edge just after that third edge. For every vector that should raise the change bit, it also samples once on the falling edge after the second rising edge and expects the bit to still be clear there.

A status read, a master reset and the `other_irq` path each act through a single register. Their effect is checked on the first falling edge after the edge that captures them. The read-collision test drives `status_rd` so that it is high during the exact cycle in which the synchronised edge is detected.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int unsigned NUM_LINES = 3;
  localparam int unsigned IDX_CD    = 0;
  localparam int unsigned IDX_DSR   = 1;
  localparam int unsigned IDX_RI    = 2;
  typedef logic [NUM_LINES-1:0] mdm_lines_t;
  localparam mdm_lines_t LINES_IDLE = '1;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync
  import mdm_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  mdm_lines_t d,
  output mdm_lines_t q
);
  mdm_lines_t stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= LINES_IDLE;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= LINES_IDLE;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/mdm_edge_qual.sv
module mdm_edge_qual
  import mdm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  mdm_lines_t lines,
  input  logic       dtr_on,
  input  logic       loop_mode,
  output logic       evt
);
  mdm_lines_t prev_q;
  mdm_lines_t fall, rise;
  logic       cd_hit, dsr_hit, ri_hit;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= LINES_IDLE;
    else     prev_q <= lines;
  end

  always_comb begin
    fall    = prev_q & ~lines;
    rise    = ~prev_q & lines;
    cd_hit  = dtr_on & (fall[IDX_CD] | rise[IDX_CD]);
    dsr_hit = dtr_on & (fall[IDX_DSR] | rise[IDX_DSR]);
    ri_hit  = ~dtr_on & ~loop_mode & fall[IDX_RI];
    evt     = cd_hit | dsr_hit | ri_hit;
  end

  // R5: loop mode with DTR off leaves no event source at all
  a_r5_loop_quiet: assert property (@(posedge clk) disable iff (rst)
    (loop_mode && !dtr_on) |-> !evt);
  // R4: with DTR on, an event needs a carrier or DSR level change
  a_r4_dtr_on_lines: assert property (@(posedge clk) disable iff (rst)
    (dtr_on && lines[IDX_CD] == prev_q[IDX_CD] && lines[IDX_DSR] == prev_q[IDX_DSR]) |-> !evt);
endmodule

// File: rtl/mdm_change_latch.sv
module mdm_change_latch (
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic status_rd,
  input  logic other_irq,
  output logic chg_q,
  output logic irq_q
);
  logic chg_d;

  always_comb chg_d = evt | (chg_q & ~status_rd);

  always_ff @(posedge clk) begin
    if (rst) begin
      chg_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      chg_q <= chg_d;
      irq_q <= chg_d | other_irq;
    end
  end

  // R6: the bit is sticky without a read
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    (chg_q && !status_rd) |=> chg_q);
  // R6: a read with no coincident event clears it
  a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
    (status_rd && !evt) |=> !chg_q);
  // R7: an event is never lost, even against a read
  a_r7_event_sets: assert property (@(posedge clk) disable iff (rst)
    evt |=> chg_q);
  // R9: the interrupt covers the change bit
  a_r9_irq_covers: assert property (@(posedge clk) disable iff (rst)
    chg_q |-> irq_q);
endmodule

// File: rtl/mdm_status_irq.sv
module mdm_status_irq
  import mdm_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cd_n,
  input  logic dsr_n,
  input  logic ri_n,
  input  logic dtr_on,
  input  logic loop_mode,
  input  logic status_rd,
  input  logic other_irq,
  output logic cd_stat,
  output logic dsr_stat,
  output logic chg_stat,
  output logic irq
);
  mdm_lines_t pins, synced;
  logic       evt;

  always_comb begin
    pins          = LINES_IDLE;
    pins[IDX_CD]  = cd_n;
    pins[IDX_DSR] = dsr_n;
    pins[IDX_RI]  = ri_n;
  end

  mdm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pins),
    .q   (synced)
  );

  mdm_edge_qual u_qual (
    .clk       (clk),
    .rst       (rst),
    .lines     (synced),
    .dtr_on    (dtr_on),
    .loop_mode (loop_mode),
    .evt       (evt)
  );

  mdm_change_latch u_latch (
    .clk       (clk),
    .rst       (rst),
    .evt       (evt),
    .status_rd (status_rd),
    .other_irq (other_irq),
    .chg_q     (chg_stat),
    .irq_q     (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cd_stat  <= 1'b0;
      dsr_stat <= 1'b0;
    end else begin
      cd_stat  <= ~synced[IDX_CD];
      dsr_stat <= ~synced[IDX_DSR];
    end
  end

  // R10: reset clears all outputs on the next edge
  a_r10_reset_clear: assert property (@(posedge clk)
    rst |=> (!chg_stat && !irq && !cd_stat && !dsr_stat));
  // R8: a level bit moves only when the synchronised pin moves
  a_r8_cd_level: assert property (@(posedge clk) disable iff (rst)
    $stable(synced[IDX_CD]) |=> $stable(cd_stat));
endmodule

// File: tb/mdm_status_irq_bench.sv
module mdm_status_irq_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cd_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1;
  logic dtr_on = 1'b1, loop_mode = 1'b0, status_rd = 1'b0, other_irq = 1'b0;
  logic cd_stat, dsr_stat, chg_stat, irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  mdm_status_irq #(.SYNC_STAGES(2)) u_mdm_status_irq (
    .clk(clk), .rst(rst), .cd_n(cd_n), .dsr_n(dsr_n), .ri_n(ri_n),
    .dtr_on(dtr_on), .loop_mode(loop_mode), .status_rd(status_rd),
    .other_irq(other_irq), .cd_stat(cd_stat), .dsr_stat(dsr_stat),
    .chg_stat(chg_stat), .irq(irq)
  );

  // fields: dtr_on, loop_mode, cd_n, dsr_n, ri_n, expected chg_stat
  localparam logic [5:0] VEC [16] = '{
    6'b100111, 6'b101111, 6'b101011, 6'b101111,
    6'b101100, 6'b101110, 6'b001110, 6'b000110,
    6'b001110, 6'b001101, 6'b001110, 6'b011100,
    6'b011110, 6'b001010, 6'b001110, 6'b101110
  };

  function automatic string vtag(input int i);
    case (i)
      0, 1:   return "R1";
      2, 3:   return "R2";
      9, 10:  return "R3";
      11, 12: return "R5";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_read();
    status_rd = 1'b1;
    edges(1);
    status_rd = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    edges(3);
    chk("R10", "chg after reset", chg_stat, 1'b0);
    chk("R10", "irq after reset", irq, 1'b0);
    chk("R10", "cd_stat after reset", cd_stat, 1'b0);
    chk("R10", "dsr_stat after reset", dsr_stat, 1'b0);
    rst = 1'b0;
    edges(4);

    for (int i = 0; i < 16; i++) begin
      {dtr_on, loop_mode, cd_n, dsr_n, ri_n} = VEC[i][5:1];
      edges(2);
      if (VEC[i][0]) chk("R11", $sformatf("chg early v%0d", i), chg_stat, 1'b0);
      edges(1);
      chk(vtag(i), $sformatf("chg v%0d", i), chg_stat, VEC[i][0]);
      chk("R9", $sformatf("irq v%0d", i), irq, VEC[i][0]);
      chk("R8", $sformatf("cd_stat v%0d", i), cd_stat, ~cd_n);
      chk("R8", $sformatf("dsr_stat v%0d", i), dsr_stat, ~dsr_n);
      do_read();
      chk("R6", $sformatf("chg after read v%0d", i), chg_stat, 1'b0);
      chk("R9", $sformatf("irq after read v%0d", i), irq, 1'b0);
      edges(1);
    end

    // sticky without read
    dtr_on = 1'b1; loop_mode = 1'b0;
    cd_n = 1'b0;
    edges(3);
    edges(20);
    chk("R6", "chg held without read", chg_stat, 1'b1);
    chk("R8", "cd_stat low pin", cd_stat, 1'b1);
    do_read();
    chk("R6", "chg cleared", chg_stat, 1'b0);

    // read coinciding with the detect cycle
    cd_n = 1'b1;
    edges(2);
    status_rd = 1'b1;
    edges(1);
    status_rd = 1'b0;
    chk("R7", "chg kept on read collision", chg_stat, 1'b1);
    chk("R7", "irq kept on read collision", irq, 1'b1);
    do_read();
    chk("R7", "chg cleared after collision", chg_stat, 1'b0);

    // other interrupt source
    other_irq = 1'b1;
    edges(1);
    chk("R9", "irq from other source", irq, 1'b1);
    chk("R9", "chg untouched by other source", chg_stat, 1'b0);
    other_irq = 1'b0;
    edges(1);
    chk("R9", "irq released", irq, 1'b0);

    // master reset releases a pending change
    dsr_n = 1'b0;
    edges(3);
    chk("R2", "dsr fall before reset", chg_stat, 1'b1);
    rst = 1'b1;
    edges(1);
    chk("R10", "chg cleared by reset", chg_stat, 1'b0);
    chk("R10", "irq cleared by reset", irq, 1'b0);
    chk("R10", "dsr_stat cleared by reset", dsr_stat, 1'b0);
    dsr_n = 1'b1;
    edges(1);
    rst = 1'b0;
    edges(5);
    chk("R10", "no event after reset release", chg_stat, 1'b0);

    finish_run();
  end
endmodule